// File: doc/BRIEF.md
# Serial NOR Read Command Sequencer with Address-Width Policies

This block sits in front of a single-lane SPI byte shifter and turns read requests carrying a 32-bit byte address into framed command byte streams for a serial NOR flash larger than 16 MiB. A configuration input picks one of three ways to reach the upper address space:
- a dedicated read opcode that always carries four address bytes;
- the legacy three-byte read, preceded when needed by a rewrite of the device's extended address byte;
- the legacy read issued while the device sits in its persistent four-byte address mode.

The host can also request the commands that switch that persistent mode on and off. The block keeps its own copy of the device's mode and of the extended address byte so that it sends each read with the right number of address bytes.

Each command is framed by the chip-select output. Bytes go out one at a time on a valid/ready byte handshake with the shifter. After the address the block emits filler bytes, flagged as data slots, so the shifter can clock in the read data. A request is taken whenever the block is not busy. The busy output covers every command the request produced.

Top module: `spinor_cmd_gen`

## Requirements
- R1: While reset is asserted, csN is high, byteValid is low, busy is low and addrMode4 is low. Reset leaves the cached extended address byte at 0x00.
- R2: A request (reqValid high while busy is low) is accepted on that clock edge and busy is high from the next cycle. Busy falls in the cycle after the last byte of the last command for that request is handed over (byteValid and byteReady both high).
- R3: With cfgPolicy = 0 (dedicated opcode), a read is sent as opcode 0x13 followed by four address bytes, most significant first.
- R4: With cfgPolicy = 2 or 3 (mode-tracked legacy) and the device not in four-byte mode, a read is sent as opcode 0x03 followed by reqAddr[23:16], reqAddr[15:8], reqAddr[7:0]. reqAddr[31:24] is not sent.
- R5: reqKind = 1 sends the single-byte command 0xB7 and reqKind = 2 sends 0xE9 (reqKind 0 and 3 mean read). addrMode4 goes high after 0xB7 and low after 0xE9. While it is high, opcode 0x03 carries four address bytes.
- R6: With cfgPolicy = 1 (extended register), not in four-byte mode, and reqAddr[31:24] different from the cached byte, the block first sends 0x06 as its own command, then 0xC5 followed by reqAddr[31:24], then the 0x03 read with three address bytes. The cached byte then equals reqAddr[31:24].
- R7: With cfgPolicy = 1 and reqAddr[31:24] equal to the cached byte, only the 0x03 read with three address bytes is sent.
- R8: With cfgPolicy = 1 while in four-byte mode, no register write is sent and the 0x03 read carries four address bytes.
- R9: A read ends with reqLen filler bytes of value 0xFF with byteIsData high. byteIsData is low on every opcode and address byte.
- R10: Chip select is high for at least GAP_CYCLES clock cycles between any two commands. It rises in the cycle after a command's last byte is handed over.
- R11: While byteValid is high and byteReady is low, byteValid, byteData and byteIsData hold their values.
- R12: cfgPolicy is sampled when the request is accepted. Changes to it while busy do not alter the bytes of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgPolicy | input | 2 | Addressing policy: 0 dedicated opcode, 1 extended register, 2/3 mode-tracked |
| reqValid | input | 1 | Request present; taken when busy is low |
| reqKind | input | 2 | 0/3 read, 1 enter four-byte mode, 2 leave four-byte mode |
| reqAddr | input | 32 | Byte address of the read |
| reqLen | input | LEN_W | Number of data byte slots after the address |
| busy | output | 1 | A request is being turned into commands |
| csN | output | 1 | Chip select to the flash, active low |
| byteValid | output | 1 | byteData holds a byte for the shifter |
| byteReady | input | 1 | Shifter takes the byte on this edge |
| byteData | output | 8 | Byte to shift out |
| byteIsData | output | 1 | Byte is a filler slot whose returned data is read data |
| addrMode4 | output | 1 | Tracked device state: four-byte address mode active |

## Verification
The hardest case to reach is a read under the extended-register policy that needs no register write. That depends on the block's hidden cache. The stimulus first forces a write with one top byte, then sends a read with the same top byte, and later returns to 0x00.

The other hard case is the extended-register policy while the device is in four-byte mode. Here the cache must be bypassed even though the top byte differs. It is reached by entering the mode with a 0xB7 request before an extended-register read, then leaving it and reading again.

A shifter-side ready pattern that stalls at random exercises byte holding inside commands and across the chip-select gap.

// File: rtl/spinor_pkg.sv
`timescale 1ns/1ps
package spinor_pkg;

  localparam logic [7:0] OP_READ_LEGACY = 8'h03;
  localparam logic [7:0] OP_READ_WIDE   = 8'h13;
  localparam logic [7:0] OP_MODE4_ON    = 8'hB7;
  localparam logic [7:0] OP_MODE4_OFF   = 8'hE9;
  localparam logic [7:0] OP_WRITE_EN    = 8'h06;
  localparam logic [7:0] OP_SET_TOPBYTE = 8'hC5;
  localparam logic [7:0] FILL_BYTE      = 8'hFF;

  localparam int ADDR_W = 32;

  typedef enum logic [1:0] {
    POL_WIDE_OPC = 2'd0,
    POL_TOP_REG  = 2'd1,
    POL_MODE_A   = 2'd2,
    POL_MODE_B   = 2'd3
  } policy_e;

  typedef enum logic [1:0] {
    JOB_READ = 2'd0,
    JOB_ON4  = 2'd1,
    JOB_OFF4 = 2'd2
  } jobKind_e;

  typedef enum logic [1:0] {
    STEP_WREN  = 2'd0,
    STEP_WRTOP = 2'd1,
    STEP_MAIN  = 2'd2
  } step_e;

  typedef struct packed {
    logic  loadJob;
    logic  startCmd;
    step_e startSel;
    logic  stepByte;
    logic  finishCmd;
  } ctrlStrobe_t;

endpackage

// File: rtl/spinor_cmd_dp.sv
`timescale 1ns/1ps
module spinor_cmd_dp
  import spinor_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [1:0]        cfgPolicy,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic [7:0]        byteData,
  output logic              byteIsData,
  output logic              lastByte,
  output logic              needTopWrite,
  output logic              addrMode4
);

  localparam int IDX_W = LEN_W + 2;

  logic [ADDR_W-1:0] jobAddr;
  logic [LEN_W-1:0]  jobLen;
  jobKind_e          jobKind;
  policy_e           jobPolicy;
  logic [7:0]        topCache;
  logic              mode4;
  step_e             curStep;
  logic [IDX_W-1:0]  byteIdx;

  logic [2:0]        addrBytes;
  logic [IDX_W-1:0]  cmdTotal;
  logic [2:0]        shiftSel;
  logic [7:0]        addrByte;
  logic              inFill;

  // job capture and tracked device state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      jobAddr   <= '0;
      jobLen    <= '0;
      jobKind   <= JOB_READ;
      jobPolicy <= POL_WIDE_OPC;
      topCache  <= 8'h00;
      mode4     <= 1'b0;
      curStep   <= STEP_MAIN;
      byteIdx   <= '0;
    end else begin
      if (strobe.loadJob) begin
        jobAddr   <= reqAddr;
        jobLen    <= reqLen;
        jobPolicy <= policy_e'(cfgPolicy);
        case (reqKind)
          2'd1:    jobKind <= JOB_ON4;
          2'd2:    jobKind <= JOB_OFF4;
          default: jobKind <= JOB_READ;
        endcase
      end
      if (strobe.startCmd) begin
        curStep <= strobe.startSel;
        byteIdx <= '0;
      end else if (strobe.stepByte) begin
        byteIdx <= byteIdx + IDX_W'(1);
      end
      if (strobe.finishCmd) begin
        if (curStep == STEP_WRTOP) topCache <= jobAddr[31:24];
        if (curStep == STEP_MAIN && jobKind == JOB_ON4)  mode4 <= 1'b1;
        if (curStep == STEP_MAIN && jobKind == JOB_OFF4) mode4 <= 1'b0;
      end
    end
  end

  // the wide opcode always carries four bytes; the legacy one follows the device mode
  always_comb begin
    addrBytes = (jobPolicy == POL_WIDE_OPC || mode4) ? 3'd4 : 3'd3;
    needTopWrite = (jobPolicy == POL_TOP_REG) && (jobKind == JOB_READ) &&
                   !mode4 && (jobAddr[31:24] != topCache);
  end

  always_comb begin
    case (curStep)
      STEP_WREN:  cmdTotal = IDX_W'(1);
      STEP_WRTOP: cmdTotal = IDX_W'(2);
      default: begin
        if (jobKind == JOB_READ)
          cmdTotal = IDX_W'(1) + IDX_W'(addrBytes) + IDX_W'(jobLen);
        else
          cmdTotal = IDX_W'(1);
      end
    endcase
    lastByte = (byteIdx == cmdTotal - IDX_W'(1));
  end

  // address bytes leave most significant first
  always_comb begin
    shiftSel = addrBytes - byteIdx[2:0];
    case (shiftSel)
      3'd0:    addrByte = jobAddr[7:0];
      3'd1:    addrByte = jobAddr[15:8];
      3'd2:    addrByte = jobAddr[23:16];
      default: addrByte = jobAddr[31:24];
    endcase
    inFill = (byteIdx > IDX_W'(addrBytes));
  end

  always_comb begin
    byteData   = FILL_BYTE;
    byteIsData = 1'b0;
    case (curStep)
      STEP_WREN:  byteData = OP_WRITE_EN;
      STEP_WRTOP: byteData = (byteIdx == '0) ? OP_SET_TOPBYTE : jobAddr[31:24];
      default: begin
        case (jobKind)
          JOB_ON4:  byteData = OP_MODE4_ON;
          JOB_OFF4: byteData = OP_MODE4_OFF;
          default: begin
            if (byteIdx == '0)
              byteData = (jobPolicy == POL_WIDE_OPC) ? OP_READ_WIDE : OP_READ_LEGACY;
            else if (inFill) begin
              byteData   = FILL_BYTE;
              byteIsData = 1'b1;
            end else
              byteData = addrByte;
          end
        endcase
      end
    endcase
  end

  assign addrMode4 = mode4;

endmodule

// File: rtl/spinor_cmd_ctrl.sv
`timescale 1ns/1ps
module spinor_cmd_ctrl
  import spinor_pkg::*;
#(
  parameter int GAP_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        byteReady,
  input  logic        lastByte,
  input  logic        needTopWrite,
  output ctrlStrobe_t strobe,
  output logic        csN,
  output logic        byteValid,
  output logic        busy
);

  localparam int CNT_W = $clog2(GAP_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_GAP} state_e;

  state_e          state;
  logic            haveJob;
  logic            midJob;
  step_e           curSel;
  step_e           pendSel;
  logic [CNT_W-1:0] gapCnt;
  step_e           firstSel;
  step_e           afterSel;

  always_comb begin
    firstSel = needTopWrite ? STEP_WREN : STEP_MAIN;
    afterSel = (curSel == STEP_WREN) ? STEP_WRTOP : STEP_MAIN;
  end

  always_comb begin
    strobe         = '0;
    strobe.loadJob = reqValid && !haveJob;
    case (state)
      ST_IDLE: begin
        if (haveJob) begin
          strobe.startCmd = 1'b1;
          strobe.startSel = firstSel;
        end
      end
      ST_SEND: begin
        if (byteReady) begin
          if (lastByte) strobe.finishCmd = 1'b1;
          else          strobe.stepByte  = 1'b1;
        end
      end
      default: begin
        if (gapCnt == '0 && (midJob || haveJob)) begin
          strobe.startCmd = 1'b1;
          strobe.startSel = midJob ? pendSel : firstSel;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      haveJob <= 1'b0;
      midJob  <= 1'b0;
      curSel  <= STEP_MAIN;
      pendSel <= STEP_MAIN;
      gapCnt  <= '0;
    end else begin
      if (strobe.loadJob) haveJob <= 1'b1;
      if (strobe.startCmd) begin
        state  <= ST_SEND;
        curSel <= strobe.startSel;
        midJob <= 1'b0;
      end
      if (strobe.finishCmd) begin
        state  <= ST_GAP;
        gapCnt <= CNT_W'(GAP_CYCLES - 1);
        if (curSel == STEP_MAIN) begin
          haveJob <= 1'b0;
        end else begin
          midJob  <= 1'b1;
          pendSel <= afterSel;
        end
      end
      if (state == ST_GAP && !strobe.startCmd) begin
        if (gapCnt != '0)        gapCnt <= gapCnt - CNT_W'(1);
        else if (!haveJob)       state  <= ST_IDLE;
      end
    end
  end

  assign csN       = (state != ST_SEND);
  assign byteValid = (state == ST_SEND);
  assign busy      = haveJob;

endmodule

// File: rtl/spinor_cmd_gen.sv
`timescale 1ns/1ps
module spinor_cmd_gen
  import spinor_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int GAP_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgPolicy,
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  input  logic [31:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  output logic             busy,
  output logic             csN,
  output logic             byteValid,
  input  logic             byteReady,
  output logic [7:0]       byteData,
  output logic             byteIsData,
  output logic             addrMode4
);

  ctrlStrobe_t strobe;
  logic        lastByte;
  logic        needTopWrite;

  spinor_cmd_ctrl #(.GAP_CYCLES(GAP_CYCLES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .byteReady    (byteReady),
    .lastByte     (lastByte),
    .needTopWrite (needTopWrite),
    .strobe       (strobe),
    .csN          (csN),
    .byteValid    (byteValid),
    .busy         (busy)
  );

  spinor_cmd_dp #(.LEN_W(LEN_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cfgPolicy    (cfgPolicy),
    .reqKind      (reqKind),
    .reqAddr      (reqAddr),
    .reqLen       (reqLen),
    .byteData     (byteData),
    .byteIsData   (byteIsData),
    .lastByte     (lastByte),
    .needTopWrite (needTopWrite),
    .addrMode4    (addrMode4)
  );

endmodule

// File: rtl/spinor_cmd_chk.sv
`timescale 1ns/1ps
module spinor_cmd_chk #(
  parameter int GAP_CYCLES = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       busy,
  input logic       csN,
  input logic       byteValid,
  input logic       byteReady,
  input logic [7:0] byteData,
  input logic       byteIsData,
  input logic       addrMode4
);

  localparam int HC_W = $clog2(GAP_CYCLES + 2);

  logic [HC_W-1:0] highCnt;
  logic            prevCsN;
  logic            seenCmd;
  logic            atFirst;
  logic            hs;

  assign hs = byteValid && byteReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt <= '0;
      prevCsN <= 1'b1;
      seenCmd <= 1'b0;
      atFirst <= 1'b1;
    end else begin
      prevCsN <= csN;
      if (csN) begin
        atFirst <= 1'b1;
        if (highCnt < HC_W'(GAP_CYCLES)) highCnt <= highCnt + HC_W'(1);
      end else begin
        highCnt <= '0;
        seenCmd <= 1'b1;
        if (hs) atFirst <= 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_r1: assert (csN && !byteValid && !busy && !addrMode4)
        else $error("outputs not idle during reset");
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !busy |=> busy);

  p_opcode_r3: assert property (@(posedge clk) disable iff (!rstN)
    hs && atFirst |-> !byteIsData &&
      (byteData == 8'h03 || byteData == 8'h13 || byteData == 8'h06 ||
       byteData == 8'hC5 || byteData == 8'hB7 || byteData == 8'hE9));

  p_mode_on_r5: assert property (@(posedge clk) disable iff (!rstN)
    hs && atFirst && byteData == 8'hB7 |=> addrMode4);

  p_mode_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    hs && atFirst && byteData == 8'hE9 |=> !addrMode4);

  p_fill_r9: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && byteIsData |-> byteData == 8'hFF);

  p_gap_r10: assert property (@(posedge clk) disable iff (!rstN)
    prevCsN && !csN && seenCmd |-> highCnt >= HC_W'(GAP_CYCLES));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && !byteReady |=> byteValid && $stable(byteData) && $stable(byteIsData));

endmodule

bind spinor_cmd_gen spinor_cmd_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .busy       (busy),
  .csN        (csN),
  .byteValid  (byteValid),
  .byteReady  (byteReady),
  .byteData   (byteData),
  .byteIsData (byteIsData),
  .addrMode4  (addrMode4)
);

// File: tb/tb_spinor_cmd_gen.sv
`timescale 1ns/1ps
module tb_spinor_cmd_gen;

  localparam int LEN_W = 8;
  localparam int GAP   = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       cfgPolicy = 2'd0;
  logic             reqValid = 1'b0;
  logic [1:0]       reqKind = 2'd0;
  logic [31:0]      reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic             busy, csN, byteValid, byteIsData, addrMode4;
  logic             byteReady = 1'b0;
  logic [7:0]       byteData;

  always #2.5 clk = ~clk;

  spinor_cmd_gen #(.LEN_W(LEN_W), .GAP_CYCLES(GAP)) dut (
    .clk(clk), .rstN(rstN), .cfgPolicy(cfgPolicy), .reqValid(reqValid),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqLen(reqLen), .busy(busy),
    .csN(csN), .byteValid(byteValid), .byteReady(byteReady),
    .byteData(byteData), .byteIsData(byteIsData), .addrMode4(addrMode4)
  );

  int nChecks = 0;
  int nFails  = 0;

  // reference model: expected byte stream
  logic [7:0] expData[$];
  bit         expIsData[$];
  bit         expLast[$];
  bit         expJobEnd[$];
  string      expReq[$];
  logic [7:0] mTop = 8'h00;
  bit         mMode4 = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input bit isD, input bit last,
                      input bit jobEnd, input string req);
    expData.push_back(d);
    expIsData.push_back(isD);
    expLast.push_back(last);
    expJobEnd.push_back(jobEnd);
    expReq.push_back(req);
  endtask

  task automatic modelRead(input logic [1:0] pol, input logic [31:0] a,
                           input int len, input string tagOver);
    string tag;
    int    nA;
    if (pol == 2'd1 && !mMode4 && a[31:24] != mTop) begin
      push(8'h06, 0, 1, 0, "R6");
      push(8'hC5, 0, 0, 0, "R6");
      push(a[31:24], 0, 1, 0, "R6");
      mTop = a[31:24];
      tag = "R6";
    end else if (pol == 2'd1) tag = mMode4 ? "R8" : "R7";
    else if (pol == 2'd0)     tag = "R3";
    else                      tag = mMode4 ? "R5" : "R4";
    if (tagOver != "") tag = tagOver;
    nA = (pol == 2'd0 || mMode4) ? 4 : 3;
    push((pol == 2'd0) ? 8'h13 : 8'h03, 0, 0, 0, tag);
    for (int k = nA - 1; k >= 0; k--)
      push(8'((a >> (8 * k)) & 32'hFF), 0, (k == 0 && len == 0), (k == 0 && len == 0), tag);
    for (int j = 0; j < len; j++)
      push(8'hFF, 1, (j == len - 1), (j == len - 1), "R9");
  endtask

  task automatic issue(input logic [1:0] kind, input logic [1:0] pol,
                       input logic [31:0] a, input int len, input string tagOver);
    @(negedge clk);
    while (busy) @(negedge clk);
    cfgPolicy = pol;
    reqKind   = kind;
    reqAddr   = a;
    reqLen    = LEN_W'(len);
    reqValid  = 1'b1;
    if (kind == 2'd1) begin
      push(8'hB7, 0, 1, 1, "R5"); mMode4 = 1'b1;
    end else if (kind == 2'd2) begin
      push(8'hE9, 0, 1, 1, "R5"); mMode4 = 1'b0;
    end else
      modelRead(pol, a, len, tagOver);
    @(negedge clk);
    reqValid  = 1'b0;
    reqAddr   = ~a;
    cfgPolicy = pol ^ 2'b01;  // R12: policy change while busy must not matter
    chk(busy === 1'b1, "R2", "busy after accept", {31'd0, busy}, 32'd1);
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (expData.size() != 0 || busy) @(negedge clk);
    @(negedge clk);
  endtask

  // per-cycle compare against the model; also drives the shifter's ready
  bit         running = 1'b0;
  bit         stallPend = 1'b0;
  logic [7:0] stallData;
  bit         stallIsD;
  bit         expCsRise = 1'b0;
  bit         expIdle = 1'b0;
  bit         seenCmd = 1'b0;
  bit         prevCs = 1'b1;
  int         highRun = 0;
  logic [7:0] lfsr = 8'hA5;

  always @(negedge clk) begin
    if (running) begin
      if (stallPend) begin
        chk(byteValid && byteData == stallData && byteIsData == stallIsD, "R11",
            "held byte", {23'd0, byteValid, byteData}, {24'd1, stallData});
      end
      if (expCsRise) begin
        chk(csN === 1'b1, "R10", "csN after last byte", {31'd0, csN}, 32'd1);
        expCsRise = 1'b0;
      end
      if (expIdle) begin
        chk(busy === 1'b0, "R2", "busy after final byte", {31'd0, busy}, 32'd0);
        expIdle = 1'b0;
      end
      if (csN) highRun++;
      else begin
        if (prevCs && seenCmd)
          chk(highRun >= GAP, "R10", "csN high gap", highRun, GAP);
        seenCmd = 1'b1;
        highRun = 0;
      end
      prevCs = csN;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      byteReady = lfsr[0] | lfsr[1];
      stallPend = byteValid && !byteReady;
      stallData = byteData;
      stallIsD  = byteIsData;
      if (byteValid && byteReady) begin
        if (expData.size() == 0) begin
          chk(1'b0, "R2", "unexpected byte", {24'd0, byteData}, 32'd0);
        end else begin
          logic [7:0] d;
          bit isD, last, jobEnd;
          string r;
          d = expData.pop_front(); isD = expIsData.pop_front();
          last = expLast.pop_front(); jobEnd = expJobEnd.pop_front();
          r = expReq.pop_front();
          chk(byteData == d && byteIsData == isD && csN == 1'b0, r, "byte",
              {23'd0, byteIsData, byteData}, {23'd0, isD, d});
          if (last)   expCsRise = 1'b1;
          if (jobEnd) expIdle = 1'b1;
        end
      end
    end
  end

  initial begin
    #(2.5 * 2 * 150000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(csN === 1'b1 && byteValid === 1'b0 && busy === 1'b0 && addrMode4 === 1'b0,
        "R1", "reset outputs", {28'd0, csN, byteValid, busy, addrMode4}, 32'h8);
    rstN = 1'b1;
    running = 1'b1;

    issue(2'd0, 2'd0, 32'h1234_5678, 2, "");   // R3 dedicated opcode, R9 fill
    issue(2'd0, 2'd2, 32'hAB00_00FF, 0, "");   // R4 top byte dropped
    issue(2'd0, 2'd1, 32'h0511_2233, 1, "");   // R6 register write
    issue(2'd0, 2'd1, 32'h05AA_BBCC, 0, "");   // R7 cache hit
    issue(2'd0, 2'd1, 32'h0000_0010, 3, "");   // R6 back to 0x00
    issue(2'd1, 2'd2, 32'h0, 0, "");           // R5 enter
    waitIdle();
    chk(addrMode4 === 1'b1, "R5", "mode after enter", {31'd0, addrMode4}, 32'd1);
    issue(2'd0, 2'd2, 32'hDEAD_BEEF, 1, "");   // R5 four bytes on legacy opcode
    issue(2'd0, 2'd1, 32'h7700_0001, 0, "");   // R8 no write in mode
    issue(2'd2, 2'd0, 32'h0, 0, "");           // R5 exit
    waitIdle();
    chk(addrMode4 === 1'b0, "R5", "mode after exit", {31'd0, addrMode4}, 32'd0);
    issue(2'd0, 2'd1, 32'h7700_0001, 2, "");   // R6 write now needed
    issue(2'd0, 2'd0, 32'h00C0_1000, 1, "R12");// R12 policy flipped after accept
    issue(2'd3, 2'd3, 32'h0102_0304, 0, "");   // R4 kind 3 reads, policy 3
    waitIdle();
    repeat (20) @(negedge clk);
    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule